// File: doc/BRIEF.md
# Multi-Lane Hit Word Serializer

This block sits between a pixel readout core and a set of serial output lanes. It turns each 23-bit hit word into a 24-bit frame by adding a word-mark bit. When the core has no hit to offer, the block sends a sync/status frame in its place. Each frame is split across 1, 2, 4 or 6 serial lanes and shifted out one bit per serial clock cycle.

The block produces the core's readout clock by dividing the serial clock. The divide ratio equals the number of bits each lane carries per frame. Because the core is read at exactly the rate the lanes drain, no buffer is needed between them. The core offers a word and holds it until the block accepts it.

The block also enforces a framing rule for the receiver. When the column number falls from one data word to the next, the block holds the later word back until at least two sync frames have gone out. The receiver can then find where each sweep of the columns begins.

Top module: `lane_word_serializer`

## Requirements
- R1: A data frame is `{1'b1, hit_word_i}`. The sync frame is `{1'b1, 23'h000000}`. Frame bit 23 (the word mark) is 1 on every frame.
- R2: If `hit_valid_i` is low at a latch edge, the frame loaded for transmission is the sync frame.
- R3: With W = 24 / lanes serial bits per lane, `rclk_o` has a period of W serial cycles. It is high for the first W/2 cycles of each frame and low for the rest. A frame starts in the cycle where `rclk_o` rises. The latch edge is the serial edge at which `rclk_o` falls.
- R4: `take_o` is high in the serial cycle just before a latch edge when, and only when, the offered word is accepted at that edge. When `take_o` is high, `rclk_o` falls on the next edge. An offered word must be held until it is taken.
- R5: The column field is `hit_word_i[14:10]`. A valid hit whose column is lower than the column of the last data frame is refused until at least two consecutive sync frames have been loaded since that data frame. Idle syncs count toward the two.
- R6: `lane_mode_i` is encoded 0 = 1 lane, 1 = 2 lanes, 2 = 4 lanes, 3 = 6 lanes. It must be held constant while out of reset.
- R7: Lane j carries frame bits [23-j*W] down to [23-j*W-(W-1)], MSB first. Bit 23-j*W is on the lane in the first cycle of the frame.
- R8: Lanes at index greater than or equal to the lane count stay at 0.
- R9: During reset, `rclk_o` is 1 and `take_o` is 0. Lane 0 carries the mark bit of the sync frame.
- R10: A frame loaded at a latch edge is transmitted in the frame that starts at the next rise of `rclk_o`. Frames go out in the order they were loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lane_mode_i | input | 2 | Lane count select |
| hit_valid_i | input | 1 | Core offers a hit word |
| hit_word_i | input | 23 | Offered hit word (bco, column, row, adc) |
| take_o | output | 1 | Offered word accepted at the coming latch edge |
| rclk_o | output | 1 | Readout clock to the core |
| lane_o | output | 6 | Serial lane data |

## Verification
`take_o` is valid in the same cycle as the latch point, one serial edge before `rclk_o` falls. The bench samples it on the falling clock edge in that cycle. It compares the sample with the decision of its own model at the fall that follows.

A frame loaded at a latch edge goes on the lanes W/2 serial edges later, when `rclk_o` rises. Its W bits are then sampled over W consecutive falling clock edges. The expected frame is queued when the fall is seen and popped only when a complete frame has been collected at the next-but-one rise. Any drift in latency or order therefore shows up as a mismatch.

// File: rtl/lwf_pkg.sv
package lwf_pkg;
  localparam int FRAME_W   = 24;
  localparam int HIT_W     = FRAME_W - 1;
  localparam int MAX_LANES = 6;
  localparam int CNT_W     = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    LANES_1 = 2'd0,
    LANES_2 = 2'd1,
    LANES_4 = 2'd2,
    LANES_6 = 2'd3
  } lane_mode_e;

  localparam logic [FRAME_W-1:0] SYNC_FRAME = {1'b1, {HIT_W{1'b0}}};

  function automatic logic [CNT_W-1:0] bits_per_lane(lane_mode_e m);
    case (m)
      LANES_1: return CNT_W'(FRAME_W);
      LANES_2: return CNT_W'(FRAME_W / 2);
      LANES_4: return CNT_W'(FRAME_W / 4);
      default: return CNT_W'(FRAME_W / 6);
    endcase
  endfunction

  function automatic int lane_count(lane_mode_e m);
    case (m)
      LANES_1: return 1;
      LANES_2: return 2;
      LANES_4: return 4;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/lwf_clkdiv.sv
module lwf_clkdiv
  import lwf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lane_mode_e       mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rclk_o,
  output logic             latch_o,
  output logic             load_o
);
  logic [CNT_W-1:0] cnt_q, width, half;

  assign width = bits_per_lane(mode_i);
  assign half  = width >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (load_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign load_o  = (cnt_q >= width - 1'b1);
  assign latch_o = (cnt_q == half - 1'b1);
  assign rclk_o  = (cnt_q < half);
  assign cnt_o   = cnt_q;

  AST_FRAME_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (rclk_o && cnt_q == '0)); // R3
endmodule

// File: rtl/lwf_framer.sv
module lwf_framer
  import lwf_pkg::*;
#(
  parameter int COL_LSB = 10,
  parameter int COL_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               latch_i,
  input  logic               hit_valid_i,
  input  logic [HIT_W-1:0]   hit_word_i,
  output logic               take_o,
  output logic [FRAME_W-1:0] next_o
);
  localparam logic [1:0] SYNC_NEED = 2'd2;

  logic [COL_W-1:0]   col, last_col_q;
  logic [1:0]         sync_run_q;
  logic [FRAME_W-1:0] next_q;
  logic               allow;

  assign col    = hit_word_i[COL_LSB +: COL_W];
  // a falling column waits for two syncs since the last data frame
  assign allow  = (col >= last_col_q) || (sync_run_q == SYNC_NEED);
  assign take_o = latch_i && hit_valid_i && allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q     <= SYNC_FRAME;
      last_col_q <= '0;
      sync_run_q <= '0;
    end else if (latch_i) begin
      if (take_o) begin
        next_q     <= {1'b1, hit_word_i};
        last_col_q <= col;
        sync_run_q <= '0;
      end else begin
        next_q <= SYNC_FRAME;
        if (sync_run_q != SYNC_NEED) sync_run_q <= sync_run_q + 1'b1;
      end
    end
  end

  assign next_o = next_q;

  AST_IDLE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && !take_o) |=> (next_q == SYNC_FRAME)); // R2
  AST_DATA_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_i && take_o) |=> (next_q == {1'b1, $past(hit_word_i)})); // R1
  AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_run_q <= SYNC_NEED); // R5
endmodule

// File: rtl/lwf_steer.sv
module lwf_steer
  import lwf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  lane_mode_e           mode_i,
  input  logic                 load_i,
  input  logic [FRAME_W-1:0]   next_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [MAX_LANES-1:0] lane_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   width;
  int                 n_lanes;

  assign width   = bits_per_lane(mode_i);
  assign n_lanes = lane_count(mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     frame_q <= SYNC_FRAME;
    else if (load_i) frame_q <= next_i;
  end

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    int idx;
    assign idx = FRAME_W - 1 - j * int'(width) - int'(cnt_i);
    always_comb begin
      lane_o[j] = 1'b0;
      if (j < n_lanes && idx >= 0 && idx < FRAME_W) lane_o[j] = frame_q[idx[4:0]];
    end
  end

  AST_MARK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q[FRAME_W-1]); // R1
  AST_FRAME_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (frame_q == $past(next_i))); // R10
  AST_UNUSED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == LANES_1) |-> (lane_o[MAX_LANES-1:1] == '0)); // R8
endmodule

// File: rtl/lane_word_serializer.sv
module lane_word_serializer
  import lwf_pkg::*;
#(
  parameter int COL_LSB = 10,
  parameter int COL_W   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           lane_mode_i,
  input  logic                 hit_valid_i,
  input  logic [HIT_W-1:0]     hit_word_i,
  output logic                 take_o,
  output logic                 rclk_o,
  output logic [MAX_LANES-1:0] lane_o
);
  lane_mode_e         mode;
  logic [CNT_W-1:0]   cnt;
  logic               latch, load;
  logic [FRAME_W-1:0] next_frame;

  assign mode = lane_mode_e'(lane_mode_i);

  lwf_clkdiv u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode),
    .cnt_o(cnt), .rclk_o(rclk_o), .latch_o(latch), .load_o(load)
  );

  lwf_framer #(.COL_LSB(COL_LSB), .COL_W(COL_W)) u_framer (
    .clk_i(clk_i), .rst_ni(rst_ni), .latch_i(latch),
    .hit_valid_i(hit_valid_i), .hit_word_i(hit_word_i),
    .take_o(take_o), .next_o(next_frame)
  );

  lwf_steer u_steer (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .load_i(load),
    .next_i(next_frame), .cnt_i(cnt), .lane_o(lane_o)
  );

  AST_TAKE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> $fell(rclk_o)); // R4
endmodule

// File: tb/lane_word_serializer_tb.sv
`timescale 1ns/1ps
module lane_word_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  lane_mode_i = 2'd0;
  logic        hit_valid_i = 1'b0;
  logic [22:0] hit_word_i = '0;
  logic        take_o, rclk_o;
  logic [5:0]  lane_o;

  always #2.5 clk = ~clk;

  lane_word_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lane_mode_i(lane_mode_i),
    .hit_valid_i(hit_valid_i), .hit_word_i(hit_word_i),
    .take_o(take_o), .rclk_o(rclk_o), .lane_o(lane_o)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic run = 1'b0;
  int w_bits, n_lanes;

  logic [23:0] exp_q[$];
  logic        sv[16];
  logic [22:0] sw[16];
  int sn, sidx, falls;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s mode=%0d act=%h exp=%h t=%0t", req, lane_mode_i, act, exp, $time);
    end
  endtask

  function automatic logic [22:0] mk(input int col, input int row, input int adc, input int bco);
    return {8'(bco), 5'(col), 7'(row), 3'(adc)};
  endfunction

  task automatic add(input bit v, input int col);
    sv[sn] = v;
    sw[sn] = v ? mk(col, 7 * sn + 3, sn, 8'hA5 ^ sn) : '0;
    sn++;
  endtask

  // Driver and model: at each observed rclk fall, decide and queue the expected frame
  logic d_prev_r = 1'b1, take_prev = 1'b0;
  int m_last, m_run;
  always @(negedge clk) begin
    if (!run) begin
      d_prev_r = 1'b1;
      take_prev = 1'b0;
    end else begin
      if (d_prev_r && !rclk_o) begin
        logic ov, acc;
        logic [22:0] ow;
        logic [23:0] e;
        ov = (sidx < sn) ? sv[sidx] : 1'b0;
        ow = sw[sidx];
        acc = ov && ((int'(ow[14:10]) >= m_last) || m_run == 2);
        if (acc) begin
          e = {1'b1, ow}; m_last = int'(ow[14:10]); m_run = 0;
        end else begin
          e = {1'b1, 23'h0}; if (m_run < 2) m_run++;
        end
        chk(take_prev == acc, "R4 R5 take", 32'(take_prev), 32'(acc));
        exp_q.push_back(e);
        if (sidx < sn && (acc || !ov)) sidx++;
        falls++;
        hit_valid_i = (sidx < sn) ? sv[sidx] : 1'b0;
        hit_word_i  = (sidx < sn) ? sw[sidx] : '0;
      end
      d_prev_r = rclk_o;
      take_prev = take_o;
    end
  end

  // Monitor: deserialize lanes per frame and compare with the queue head
  logic m_prev_r = 1'b1, coll = 1'b0;
  int k;
  logic [23:0] rx;
  always @(negedge clk) begin
    if (!run) begin
      m_prev_r = 1'b1; coll = 1'b0; k = 0;
    end else begin
      if (rclk_o && !m_prev_r) begin
        if (coll) begin
          chk(k == w_bits, "R3 period", 32'(k), 32'(w_bits));
          if (exp_q.size() == 0) chk(1'b0, "R10 queue empty", 32'(rx), 32'h0);
          else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            chk(rx == e, "R1 R2 R5 R7 R10 frame", 32'(rx), 32'(e));
          end
        end
        coll = 1'b1; k = 0;
      end
      if (coll && k < w_bits) begin
        for (int j = 0; j < n_lanes; j++) rx[23 - j * w_bits - k] = lane_o[j];
        k++;
      end
      for (int j = n_lanes; j < 6; j++)
        if (lane_o[j] !== 1'b0) chk(1'b0, "R8 unused lane", 32'(lane_o), 32'h0);
      m_prev_r = rclk_o;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int md = 0; md < 4; md++) begin
      @(posedge clk); #1;
      run = 1'b0;
      rst_ni = 1'b0;
      lane_mode_i = 2'(md);
      hit_valid_i = 1'b0;
      hit_word_i = '0;
      exp_q.delete();
      w_bits = (md == 0) ? 24 : (md == 1) ? 12 : (md == 2) ? 6 : 4;
      n_lanes = (md == 0) ? 1 : (md == 1) ? 2 : (md == 2) ? 4 : 6;
      sn = 0; sidx = 0; falls = 0; m_last = 0; m_run = 0;
      add(1, 3); add(1, 5); add(1, 5); add(1, 2);  // equal then falling column (R5)
      add(0, 0); add(1, 1);                        // one idle sync counts toward two
      add(1, 6); add(0, 0); add(0, 0); add(1, 3);  // two idles: no extra sync
      add(1, 22); add(1, 31); add(1, 1); add(0, 0); add(1, 9);
      hit_valid_i = sv[0];
      hit_word_i = sw[0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(rclk_o == 1'b1, "R9 rclk in reset", 32'(rclk_o), 32'h1);
      chk(take_o == 1'b0, "R9 take in reset", 32'(take_o), 32'h0);
      chk(lane_o[0] == 1'b1, "R9 R6 lane0 mark", 32'(lane_o), 32'h1);
      @(posedge clk); #1;
      rst_ni = 1'b1;
      run = 1'b1;
      while (!(sidx >= sn && falls > sn + 12)) @(posedge clk);
      repeat (2 * w_bits) @(posedge clk);
      chk(sidx == sn, "R6 stimulus consumed", 32'(sidx), 32'(sn));
    end
    @(posedge clk); #1;
    run = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule